// File: doc/BRIEF.md
# Packed Half-Word Instruction Stepper

This block sequences a fetched 32-bit word that carries two 16-bit register-only instructions. It runs the upper half first. It then moves the lower half into the upper position of its instruction register, so one field decoder serves both halves. A second-half flag records which half is in progress. That flag is cleared whenever a new word is accepted, and it decides whether the sequencer runs another half or returns to wait for the next fetch.

For each half the block splits out the opcode, destination code, mode and source field. In the first active cycle it copies the source operand into an operand register. That operand is a register value, or a 4-bit immediate widened with zeros. In the second cycle the operand register drives the A-side operand path and the destination register drives the B-side path. The result comes back from an external arithmetic unit on `res_in` and is written into the destination. The block holds the three programmer-visible registers (accumulator, index, stack pointer) and shows them on its outputs. The opcode is passed out, with two decoded hints for the arithmetic unit: move and shift/rotate.

Top module: `packed_half_stepper`

## Requirements
- R1: After synchronous reset `busy`, `exec_stb`, `done` and `second_half` are 0, and `ac_q`, `ix_q` and `sp_q` are all zero.
- R2: A word is accepted only at a rising edge where `busy` is 0, `fetch_valid` is 1 and word bit 27 (the format bit of the upper half) is 0. `busy` is then 1 in the next cycle. A word whose bit 27 is 1 is ignored and `busy` stays 0. `fetch_valid` while `busy` is 1 is ignored and does not change the word being stepped.
- R3: Word bits 31:16 form the first half and bits 15:0 the second. Within a half h, the fields are: opcode h[15:12], format bit h[11], destination code h[10:7], mode h[6:5], source field h[4:1]; h[0] is ignored. `op_code` shows the opcode of the half being executed.
- R4: Register codes are 4'b0000 for the accumulator (`ac_q`), 4'b1000 for the index register (`ix_q`) and 4'b1111 for the stack pointer (`sp_q`).
- R5: In mode 2'b00 (and also 2'b01 and 2'b11), the source register value is latched in the cycle before execution. In the execute cycle (`exec_stb`=1), `a_path` carries that value and `b_path` carries the destination register. At the end of that cycle the destination register takes `res_in`. Apart from the register the half names as its destination, no register changes.
- R6: In mode 2'b10 (immediate quick), `a_path` in the execute cycle is the 4-bit source field zero-extended to the full width.
- R7: `exec_stb` is 1 for one cycle, in the second cycle after acceptance, for the first half. For the second half it is 1 again three cycles later. `second_half` is 0 from acceptance through the first execute cycle and 1 from the cycle before the second execute onward.
- R8: If the second half's format bit (word bit 11) is 1, only the first half executes. `done` is 1 in the cycle after the first execute, and `busy` is 0 in the cycle after that.
- R9: If the destination code, or the source code in a register mode, is not one of the codes of R4, no register changes. A bad source code puts zero on `a_path`, and a bad destination puts zero on `b_path`. The step still completes with normal timing.
- R10: `is_move` is 1 exactly when the opcode is 4'b0110, and `is_shift` exactly when it is 4'b1011 (the store-accumulator code of the long format, reused as shift/rotate).
- R11: `done` is 1 for one cycle in the last active cycle of a word, and `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetched word is offered |
| fetch_word | input | 32 | The fetched packed word |
| res_in | input | DW | Result from the external arithmetic unit |
| busy | output | 1 | A word is being stepped |
| second_half | output | 1 | Second-half flag |
| exec_stb | output | 1 | Execute cycle of a half |
| done | output | 1 | Last active cycle of a word |
| op_code | output | 4 | Opcode of the current half |
| is_move | output | 1 | Current opcode is the move code |
| is_shift | output | 1 | Current opcode is the shift/rotate code |
| a_path | output | DW | A-side operand (latched source) |
| b_path | output | DW | B-side operand (destination register) |
| ac_q | output | DW | Accumulator |
| ix_q | output | DW | Index register |
| sp_q | output | DW | Stack pointer |

## Verification
The hardest case is a second half that reads a register the first half has just written. Its operand must come from the updated value, which only appears if the swap and the operand latch are ordered correctly. Random words draw both halves' register codes from a small pool, which is mostly valid codes. This makes such read-after-write pairs frequent. Directed words cover the remaining cases: a rejected format bit, a second half that is switched off, an unknown register code, and a fetch offered while busy.

// File: rtl/hw_step_pkg.sv
`timescale 1ns/1ps
package hw_step_pkg;

    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int CODE_W    = 4;
    localparam int OP_W      = 4;
    localparam int MODE_W    = 2;
    localparam int NUM_REGS  = 3;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int FMT_BIT   = 11;

    localparam logic [CODE_W-1:0] CODE_ACC   = 4'b0000;
    localparam logic [CODE_W-1:0] CODE_INDEX = 4'b1000;
    localparam logic [CODE_W-1:0] CODE_STACK = 4'b1111;

    localparam logic [OP_W-1:0]   OP_MOVE    = 4'b0110;
    localparam logic [OP_W-1:0]   OP_SHIFT   = 4'b1011;
    localparam logic [MODE_W-1:0] MODE_IMMQ  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EXEC,
        ST_SWAP
    } step_state_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic              fmt;
        logic [CODE_W-1:0] dst;
        logic [MODE_W-1:0] mode;
        logic [CODE_W-1:0] src;
        logic              spare;
    } half_fields_t;

    typedef struct packed {
        logic                 valid;
        logic [REG_IDX_W-1:0] idx;
    } reg_sel_t;

    function automatic half_fields_t split_half(input logic [HALF_W-1:0] h);
        return half_fields_t'(h);
    endfunction

    function automatic reg_sel_t code_lookup(input logic [CODE_W-1:0] code);
        reg_sel_t s;
        s.valid = 1'b1;
        s.idx   = '0;
        case (code)
            CODE_ACC:   s.idx = REG_IDX_W'(0);
            CODE_INDEX: s.idx = REG_IDX_W'(1);
            CODE_STACK: s.idx = REG_IDX_W'(2);
            default:    s.valid = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hw_half_decode.sv
`timescale 1ns/1ps
module hw_half_decode
    import hw_step_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [HALF_W-1:0] half_in,
    output half_fields_t      fields,
    output reg_sel_t          dst_sel,
    output reg_sel_t          src_sel,
    output logic              use_imm,
    output logic              op_is_move,
    output logic              op_is_shift,
    output logic [DW-1:0]     imm_ext
);

    localparam int PAD_W = DW - CODE_W;

    always_comb begin
        fields      = split_half(half_in);
        dst_sel     = code_lookup(fields.dst);
        src_sel     = code_lookup(fields.src);
        use_imm     = (fields.mode == MODE_IMMQ);
        op_is_move  = (fields.op == OP_MOVE);
        op_is_shift = (fields.op == OP_SHIFT);
        imm_ext     = {{PAD_W{1'b0}}, fields.src};
    end

endmodule

// File: rtl/hw_reg_bank.sv
`timescale 1ns/1ps
module hw_reg_bank
    import hw_step_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = NUM_REGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  reg_sel_t                 wr_sel,
    input  logic [DW-1:0]            wr_data,
    input  reg_sel_t                 rd_a_sel,
    input  reg_sel_t                 rd_b_sel,
    output logic [DW-1:0]            rd_a,
    output logic [DW-1:0]            rd_b,
    output logic [NREG-1:0][DW-1:0]  regs_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && wr_sel.valid && (wr_sel.idx == REG_IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (hit) begin
                regs_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_a = '0;
        rd_b = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_a_sel.valid && (rd_a_sel.idx == REG_IDX_W'(i))) begin
                rd_a = regs_q[i];
            end
            if (rd_b_sel.valid && (rd_b_sel.idx == REG_IDX_W'(i))) begin
                rd_b = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/hw_step_ctrl.sv
`timescale 1ns/1ps
module hw_step_ctrl
    import hw_step_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_valid,
    input  logic        upper_fmt,
    input  logic        lower_fmt,
    output step_state_t state,
    output logic        load_ir,
    output logic        swap_ir,
    output logic        half_flag,
    output logic        last_cycle
);

    step_state_t state_n;

    always_comb begin
        state_n    = state;
        load_ir    = 1'b0;
        swap_ir    = 1'b0;
        last_cycle = 1'b0;
        case (state)
            ST_IDLE: begin
                if (fetch_valid && !upper_fmt) begin
                    load_ir = 1'b1;
                    state_n = ST_LOAD;
                end
            end
            ST_LOAD: state_n = ST_EXEC;
            ST_EXEC: begin
                if (half_flag) begin
                    last_cycle = 1'b1;
                    state_n    = ST_IDLE;
                end else begin
                    state_n = ST_SWAP;
                end
            end
            ST_SWAP: begin
                if (lower_fmt) begin
                    last_cycle = 1'b1;
                    state_n    = ST_IDLE;
                end else begin
                    swap_ir = 1'b1;
                    state_n = ST_LOAD;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            half_flag <= 1'b0;
        end else begin
            state <= state_n;
            if (load_ir) begin
                half_flag <= 1'b0;
            end else if (swap_ir) begin
                half_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/packed_half_stepper.sv
`timescale 1ns/1ps
module packed_half_stepper
    import hw_step_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_word,
    input  logic [DW-1:0]     res_in,
    output logic              busy,
    output logic              second_half,
    output logic              exec_stb,
    output logic              done,
    output logic [3:0]        op_code,
    output logic              is_move,
    output logic              is_shift,
    output logic [DW-1:0]     a_path,
    output logic [DW-1:0]     b_path,
    output logic [DW-1:0]     ac_q,
    output logic [DW-1:0]     ix_q,
    output logic [DW-1:0]     sp_q
);

    localparam int NREG = NUM_REGS;

    logic [WORD_W-1:0]       ir_q;
    logic [DW-1:0]           md_q;
    step_state_t             st;
    logic                    load_ir;
    logic                    swap_ir;
    logic                    half_flag;
    logic                    last_cycle;
    half_fields_t            fld;
    reg_sel_t                dsel;
    reg_sel_t                ssel;
    logic                    use_imm;
    logic                    mv_w;
    logic                    sh_w;
    logic [DW-1:0]           imm_ext;
    logic [DW-1:0]           rd_src;
    logic [DW-1:0]           rd_dst;
    logic [NREG-1:0][DW-1:0] regs_q;
    logic                    wr_en;

    hw_step_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fetch_valid(fetch_valid),
        .upper_fmt  (fetch_word[HALF_W + FMT_BIT]),
        .lower_fmt  (ir_q[FMT_BIT]),
        .state      (st),
        .load_ir    (load_ir),
        .swap_ir    (swap_ir),
        .half_flag  (half_flag),
        .last_cycle (last_cycle)
    );

    hw_half_decode #(.DW(DW)) u_dec (
        .half_in    (ir_q[WORD_W-1:HALF_W]),
        .fields     (fld),
        .dst_sel    (dsel),
        .src_sel    (ssel),
        .use_imm    (use_imm),
        .op_is_move (mv_w),
        .op_is_shift(sh_w),
        .imm_ext    (imm_ext)
    );

    hw_reg_bank #(.DW(DW), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (dsel),
        .wr_data (res_in),
        .rd_a_sel(ssel),
        .rd_b_sel(dsel),
        .rd_a    (rd_src),
        .rd_b    (rd_dst),
        .regs_q  (regs_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (load_ir) begin
            ir_q <= fetch_word;
        end else if (swap_ir) begin
            ir_q <= {ir_q[HALF_W-1:0], {HALF_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            md_q <= '0;
        end else if (st == ST_LOAD) begin
            if (use_imm) begin
                md_q <= imm_ext;
            end else if (ssel.valid) begin
                md_q <= rd_src;
            end else begin
                md_q <= '0;
            end
        end
    end

    assign wr_en       = (st == ST_EXEC) && dsel.valid && (use_imm || ssel.valid);
    assign busy        = (st != ST_IDLE);
    assign second_half = half_flag;
    assign exec_stb    = (st == ST_EXEC);
    assign done        = last_cycle;
    assign op_code     = fld.op;
    assign is_move     = mv_w;
    assign is_shift    = sh_w;
    assign a_path      = md_q;
    assign b_path      = rd_dst;
    assign ac_q        = regs_q[0];
    assign ix_q        = regs_q[1];
    assign sp_q        = regs_q[2];

endmodule

// File: rtl/hw_step_checker.sv
`timescale 1ns/1ps
module hw_step_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fetch_valid,
    input logic [31:0]   fetch_word,
    input logic          busy,
    input logic          second_half,
    input logic          exec_stb,
    input logic          done,
    input logic [DW-1:0] ac_q,
    input logic [DW-1:0] ix_q,
    input logic [DW-1:0] sp_q
);

    // R2: an accepted word starts the first half
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && fetch_valid && !fetch_word[27]) |=> (busy && !second_half && !exec_stb));

    // R2: a word flagged as long format is not taken
    a_r2_reject_long: assert property (@(posedge clk) disable iff (rst)
        (!busy && fetch_valid && fetch_word[27]) |=> !busy);

    // R7: execute strobe never lasts two cycles
    a_r7_single_exec: assert property (@(posedge clk) disable iff (rst)
        exec_stb |=> !exec_stb);

    // R7: after the first-half execute, the flag is set before the next half
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        (exec_stb && !second_half && !done) |=> ##1 (second_half || done || !busy));

    // R11: done is followed by idle
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R5: registers only move at the end of an execute cycle
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !exec_stb |=> ($stable(ac_q) && $stable(ix_q) && $stable(sp_q)));

    // R1: an idle stepper raises no strobes
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!exec_stb && !done));

endmodule

bind packed_half_stepper hw_step_checker #(.DW(DW)) u_step_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_valid(fetch_valid),
    .fetch_word (fetch_word),
    .busy       (busy),
    .second_half(second_half),
    .exec_stb   (exec_stb),
    .done       (done),
    .ac_q       (ac_q),
    .ix_q       (ix_q),
    .sp_q       (sp_q)
);

// File: tb/packed_half_stepper_tb_top.sv
`timescale 1ns/1ps
module packed_half_stepper_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid;
    logic [31:0] fetch_word;
    logic [31:0] res_in;
    logic        busy, second_half, exec_stb, done, is_move, is_shift;
    logic [3:0]  op_code;
    logic [31:0] a_path, b_path, ac_q, ix_q, sp_q;

    int total = 0;
    int fails = 0;
    logic [31:0] bm [3];

    always #2.5 clk = ~clk;

    packed_half_stepper #(.DW(32)) dut_i (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .res_in(res_in), .busy(busy), .second_half(second_half), .exec_stb(exec_stb),
        .done(done), .op_code(op_code), .is_move(is_move), .is_shift(is_shift),
        .a_path(a_path), .b_path(b_path), .ac_q(ac_q), .ix_q(ix_q), .sp_q(sp_q)
    );

    function automatic logic [31:0] alu_model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        if (op == 4'b0110) return a;
        return a + b + {28'd0, op};
    endfunction

    assign res_in = alu_model(op_code, a_path, b_path);

    function automatic int idx_of(logic [3:0] c);
        case (c)
            4'b0000: return 0;
            4'b1000: return 1;
            4'b1111: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] mk(logic [3:0] op, logic fmt, logic [3:0] d,
                                       logic [1:0] m, logic [3:0] s);
        return {op, fmt, d, m, s, 1'b0};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_regs(string req);
        chk(ac_q == bm[0], req, ac_q, bm[0]);
        chk(ix_q == bm[1], req, ix_q, bm[1]);
        chk(sp_q == bm[2], req, sp_q, bm[2]);
    endtask

    // sampled in an execute cycle; updates the model
    task automatic check_half(logic [15:0] h, logic exp_flag);
        logic [3:0]  op = h[15:12];
        logic [3:0]  d  = h[10:7];
        logic [1:0]  m  = h[6:5];
        logic [3:0]  s  = h[4:1];
        int          di = idx_of(d);
        int          si = idx_of(s);
        bit          imm = (m == 2'b10);
        logic [31:0] ea, eb;
        ea = imm ? {28'd0, s} : ((si >= 0) ? bm[si] : 32'd0);
        eb = (di >= 0) ? bm[di] : 32'd0;
        chk(exec_stb == 1'b1, "R7 exec strobe", {31'd0, exec_stb}, 32'd1);
        chk(second_half == exp_flag, "R7 half flag", {31'd0, second_half}, {31'd0, exp_flag});
        chk(op_code == op, "R3 opcode field", {28'd0, op_code}, {28'd0, op});
        chk(a_path == ea, imm ? "R6 immediate operand" : "R5 source operand", a_path, ea);
        chk(b_path == eb, (di >= 0) ? "R5 destination operand" : "R9 bad destination", b_path, eb);
        chk(is_move == (op == 4'b0110), "R10 move hint", {31'd0, is_move}, {31'd0, op == 4'b0110});
        chk(is_shift == (op == 4'b1011), "R10 shift hint", {31'd0, is_shift}, {31'd0, op == 4'b1011});
        if (di >= 0 && (imm || si >= 0)) bm[di] = alu_model(op, ea, eb);
    endtask

    task automatic run_word(logic [31:0] w, bit poke);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_word  = w;
        @(posedge clk);
        @(negedge clk);
        if (poke) fetch_word = 32'h6000_0000 | {16'h0, w[15:0]} ^ 32'h0F00_0000;
        else fetch_valid = 1'b0;
        chk(busy == 1'b1, "R2 accepted", {31'd0, busy}, 32'd1);
        chk(exec_stb == 1'b0, "R7 load cycle", {31'd0, exec_stb}, 32'd0);
        chk(second_half == 1'b0, "R7 flag cleared on fetch", {31'd0, second_half}, 32'd0);
        @(negedge clk);
        fetch_valid = 1'b0;
        check_half(w[31:16], 1'b0);
        chk(done == 1'b0, "R11 no early done", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk(exec_stb == 1'b0, "R7 swap cycle", {31'd0, exec_stb}, 32'd0);
        chk_regs("R5 first half write");
        if (w[11]) begin
            chk(done == 1'b1, "R8 lower half skipped", {31'd0, done}, 32'd1);
            @(negedge clk);
            chk(busy == 1'b0, "R8 idle after skip", {31'd0, busy}, 32'd0);
            chk_regs("R8 registers after skip");
            return;
        end
        chk(done == 1'b0, "R11 no done in swap", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk(second_half == 1'b1, "R7 flag set", {31'd0, second_half}, 32'd1);
        @(negedge clk);
        check_half(w[15:0], 1'b1);
        chk(done == 1'b1, "R11 done pulse", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk(busy == 1'b0, "R11 idle after done", {31'd0, busy}, 32'd0);
        chk(done == 1'b0, "R11 done single cycle", {31'd0, done}, 32'd0);
        chk_regs("R5 second half write");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #1000000;
        total++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [3:0] pool [6];
        pool = '{4'b0000, 4'b1000, 4'b1111, 4'b0000, 4'b0101, 4'b1111};
        void'($urandom(32'd20240611));
        bm[0] = '0; bm[1] = '0; bm[2] = '0;
        rst = 1'b1; fetch_valid = 1'b0; fetch_word = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0, "R1 reset busy", {31'd0, busy}, 32'd0);
        chk(second_half == 1'b0, "R1 reset flag", {31'd0, second_half}, 32'd0);
        chk(done == 1'b0 && exec_stb == 1'b0, "R1 reset strobes", {30'd0, done, exec_stb}, 32'd0);
        chk_regs("R1 reset registers");

        // R6 immediate into AC, then R4/R5 register add into IX reading the new AC
        run_word({mk(4'b0110, 1'b0, 4'b0000, 2'b10, 4'hD), mk(4'b0001, 1'b0, 4'b1000, 2'b00, 4'b0000)}, 1'b0);
        // R4 stack pointer from index, then shift op on AC
        run_word({mk(4'b0110, 1'b0, 4'b1111, 2'b00, 4'b1000), mk(4'b1011, 1'b0, 4'b0000, 2'b10, 4'hF)}, 1'b0);

        // R2 long-format word ignored
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_word  = {mk(4'b0110, 1'b1, 4'b0000, 2'b10, 4'h3), 16'h0000};
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(busy == 1'b0, "R2 long word ignored", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk_regs("R2 long word no change");

        // R8 second half disabled
        run_word({mk(4'b0010, 1'b0, 4'b1000, 2'b10, 4'h7), mk(4'b0110, 1'b1, 4'b0000, 2'b10, 4'h1)}, 1'b0);
        // R9 bad destination and bad source
        run_word({mk(4'b0110, 1'b0, 4'b0011, 2'b10, 4'h9), mk(4'b0001, 1'b0, 4'b0000, 2'b00, 4'b0100)}, 1'b0);
        // R2 fetch offered while busy
        run_word({mk(4'b0011, 1'b0, 4'b1111, 2'b10, 4'h2), mk(4'b0110, 1'b0, 4'b1000, 2'b00, 4'b1111)}, 1'b1);

        for (int n = 0; n < 60; n++) begin
            logic [15:0] hu, hl;
            hu = mk(4'($urandom), 1'b0, pool[$urandom % 6], 2'($urandom), pool[$urandom % 6]);
            hl = mk(4'($urandom), ($urandom % 8) == 0, pool[$urandom % 6], 2'($urandom),
                    ($urandom % 3 == 0) ? 4'($urandom) : pool[$urandom % 6]);
            run_word({hu, hl}, ($urandom % 10) == 0);
        end
        finish_run();
    end

endmodule